// File: doc/BRIEF.md
# Static Memory Wait-State Sequencer

This block times accesses to one chip-select of an external static-memory bus. A requester presents a request with a direction, a burst length and a start address. The block captures the configuration of that bank when it takes the request. It then holds chip-select and either output-enable or write-enable low for each beat of the burst. It steps the address once per beat and reports the end of the access with a single-cycle completion pulse.

The bank has two timing modes. In normal mode, a read takes its length from the read-wait field and a write from the write-wait field, each giving 1 to 32 cycles per beat. In extended mode, one coarse field times both directions in steps of 16 cycles, up to 16368 cycles per beat. Only in extended mode can a slow device cut a beat short: it gives a rising edge on an asynchronous acknowledge line, and the block synchronises that line inside. A bank flagged as protected refuses writes. The bus is not touched, and the requester gets a one-cycle error pulse.

Top module: `smc_wait_seq`

## Requirements
- R1: While reset is asserted and right after it, `cs_n`, `oe_n` and `we_n` are high, `req_ready` is high, and `done`, `err` and `addr_out` are zero.
- R2: In normal mode, each read beat holds `cs_n` and `oe_n` low with `we_n` high for `cfg_rd_wait`+1 cycles (1 to 32).
- R3: In normal mode, each write beat holds `cs_n` and `we_n` low with `oe_n` high for `cfg_wr_wait`+1 cycles. The read-wait field has no effect on writes.
- R4: With `cfg_ext_en`=1, every beat of a read or a write lasts (`cfg_ext_wait`+1)×16 cycles. The normal wait fields are not used.
- R5: An extended-wait field above 1022 acts as 1022, so no beat lasts longer than 16368 cycles.
- R6: In extended mode, `ack_in` rises and is first sampled high at clock edge k after being low at edge k−1. If the current beat is still running, it then ends at edge k+2, earlier than its programmed length.
- R7: Early completion is edge-triggered. Each beat of a burst needs its own rising edge, and a beat with no new edge runs its full length, however long `ack_in` stays high.
- R8: In normal mode, `ack_in` has no effect on beat length.
- R9: A write accepted while `cfg_wprot`=1 drives no strobe. `err` is high for exactly the cycle after acceptance. Reads of a protected bank and writes to an unprotected bank run normally with `err` low.
- R10: After the last beat, all strobes are high and `done` is high for one cycle with `req_ready` low. `req_ready` returns high the next cycle. A request is accepted only on an edge where `req_valid` and `req_ready` are both high.
- R11: `req_len` holds the beat count minus one (0 to 3). `addr_out` takes `req_addr` at acceptance and adds one at each beat boundary, and the strobes stay low without a break between beats.
- R12: The direction, mode and wait lengths are sampled at acceptance. Changes to the configuration or to `ack_in` mode settings during an access do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_len | input | 2 | Beats in burst minus one |
| req_addr | input | 16 | Start address |
| req_ready | output | 1 | Block idle, request can be taken |
| cfg_rd_wait | input | 5 | Normal read beat length minus one |
| cfg_wr_wait | input | 5 | Normal write beat length minus one |
| cfg_ext_en | input | 1 | Extended-wait mode enable |
| cfg_ext_wait | input | 10 | Extended beat length in units of 16, minus one |
| cfg_wprot | input | 1 | Bank write-protect |
| ack_in | input | 1 | Asynchronous early-completion strobe |
| cs_n | output | 1 | Chip-select, active low |
| oe_n | output | 1 | Output-enable, active low |
| we_n | output | 1 | Write-enable, active low |
| addr_out | output | 16 | Current beat address |
| done | output | 1 | Access complete pulse |
| err | output | 1 | Refused write pulse |

## Verification
The bench checks the acknowledge path at its exact synchroniser latency. A design with one flop too few or too many ends a beat one cycle off from the computed total. It holds the acknowledge high across several beats to catch a design that acts on the level, which would shorten every beat instead of only one. It toggles the acknowledge in normal mode and mid-access after changing the configuration, to catch a design that ignores the mode or fails to latch it at acceptance. It drives the extended field to its top code, where a design without clamping would run 16 cycles too long. It also checks protected writes, which a wrong design would put on the bus or report one cycle late.

// File: rtl/smc_wait_pkg.sv
package smc_wait_pkg;

    // Sequencer phases; outputs are decoded from the registered phase only.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BEAT  = 2'd1,
        ST_GAP   = 2'd2,
        ST_FAULT = 2'd3
    } smc_state_e;

endpackage

// File: rtl/smc_ack_edge.sv
// Synchronises the asynchronous acknowledge and produces a one-cycle pulse
// for every low-to-high transition seen after the synchroniser.
module smc_ack_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_async,
    output logic rise
);

    localparam int SH_W = SYNC_STAGES + 1;   // sync stages plus one history flop

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], ack_async};
        rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // A pulse never lasts more than one cycle: a held level must not
    // complete several beats (R7).
    assert_rise_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/smc_wait_sel.sv
// Picks the per-beat reload value (beat length minus one) from the bank
// configuration and the access direction.
module smc_wait_sel #(
    parameter int NWAIT_W   = 5,
    parameter int EXT_W     = 10,
    parameter int EXT_SHIFT = 4,
    parameter int CNT_W     = EXT_W + EXT_SHIFT
) (
    input  logic               is_write,
    input  logic               ext_en,
    input  logic [NWAIT_W-1:0] rd_wait,
    input  logic [NWAIT_W-1:0] wr_wait,
    input  logic [EXT_W-1:0]   ext_wait,
    output logic [CNT_W-1:0]   load_val
);

    localparam int EXT_CAP = (1 << EXT_W) - 2;

    logic [EXT_W-1:0] ext_cap;
    logic [CNT_W:0]   ext_len;
    logic [CNT_W-1:0] ext_load;
    logic [CNT_W-1:0] norm_load;

    always_comb begin
        ext_cap   = (ext_wait > EXT_W'(EXT_CAP)) ? EXT_W'(EXT_CAP) : ext_wait;
        ext_len   = ((CNT_W+1)'(ext_cap) + (CNT_W+1)'(1)) << EXT_SHIFT;
        ext_load  = CNT_W'(ext_len - (CNT_W+1)'(1));
        norm_load = CNT_W'(is_write ? wr_wait : rd_wait);
        load_val  = ext_en ? ext_load : norm_load;
    end

endmodule

// File: rtl/smc_wait_cnt.sv
// Down-counter for wait states within one beat.
module smc_wait_cnt #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)              cnt_d = load_val;
        else if (cnt_q != '0)  cnt_d = cnt_q - CNT_W'(1);
        else                   cnt_d = cnt_q;
        zero = (cnt_q == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // Without a reload the count parks at zero instead of wrapping (R4).
    assert_hold_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero);

endmodule

// File: rtl/smc_wait_seq.sv
module smc_wait_seq
    import smc_wait_pkg::*;
#(
    parameter int NWAIT_W     = 5,
    parameter int EXT_W       = 10,
    parameter int EXT_SHIFT   = 4,
    parameter int BURST_W     = 2,
    parameter int ADDR_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [BURST_W-1:0] req_len,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               req_ready,
    input  logic [NWAIT_W-1:0] cfg_rd_wait,
    input  logic [NWAIT_W-1:0] cfg_wr_wait,
    input  logic               cfg_ext_en,
    input  logic [EXT_W-1:0]   cfg_ext_wait,
    input  logic               cfg_wprot,
    input  logic               ack_in,
    output logic               cs_n,
    output logic               oe_n,
    output logic               we_n,
    output logic [ADDR_W-1:0]  addr_out,
    output logic               done,
    output logic               err
);

    localparam int CNT_W       = EXT_W + EXT_SHIFT;
    localparam int EXT_CAP     = (1 << EXT_W) - 2;
    localparam int EXT_MAX_LEN = (EXT_CAP + 1) << EXT_SHIFT;

    typedef struct packed {
        smc_state_e         state;
        logic               write;
        logic               ext;
        logic [BURST_W-1:0] beats;
        logic [ADDR_W-1:0]  addr;
        logic [CNT_W-1:0]   reload;
    } seq_t;

    localparam seq_t SEQ_RST = '{state: ST_IDLE, write: 1'b0, ext: 1'b0,
                                 beats: '0, addr: '0, reload: '0};

    seq_t q, d;

    logic             ack_rise;
    logic [CNT_W-1:0] sel_val;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_zero;
    logic             accept;
    logic             refuse;
    logic             beat_end;

    smc_ack_edge #(.SYNC_STAGES(SYNC_STAGES)) u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_async (ack_in),
        .rise      (ack_rise)
    );

    smc_wait_sel #(
        .NWAIT_W   (NWAIT_W),
        .EXT_W     (EXT_W),
        .EXT_SHIFT (EXT_SHIFT),
        .CNT_W     (CNT_W)
    ) u_sel (
        .is_write (req_write),
        .ext_en   (cfg_ext_en),
        .rd_wait  (cfg_rd_wait),
        .wr_wait  (cfg_wr_wait),
        .ext_wait (cfg_ext_wait),
        .load_val (sel_val)
    );

    smc_wait_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .zero     (cnt_zero)
    );

    always_comb begin
        d        = q;
        cnt_load = 1'b0;
        cnt_val  = q.reload;
        accept   = req_valid && (q.state == ST_IDLE);
        refuse   = accept && req_write && cfg_wprot;
        beat_end = (q.state == ST_BEAT) && (cnt_zero || (q.ext && ack_rise));

        case (q.state)
            ST_IDLE: begin
                if (accept) begin
                    d.addr = req_addr;
                    if (refuse) begin
                        d.state = ST_FAULT;
                    end else begin
                        d.state  = ST_BEAT;
                        d.write  = req_write;
                        d.ext    = cfg_ext_en;
                        d.beats  = req_len;
                        d.reload = sel_val;
                        cnt_load = 1'b1;
                        cnt_val  = sel_val;
                    end
                end
            end
            ST_BEAT: begin
                if (beat_end) begin
                    if (q.beats == '0) begin
                        d.state = ST_GAP;
                    end else begin
                        d.beats  = q.beats - BURST_W'(1);
                        d.addr   = q.addr + ADDR_W'(1);
                        cnt_load = 1'b1;
                    end
                end
            end
            ST_GAP:   d.state = ST_IDLE;
            ST_FAULT: d.state = ST_IDLE;
            default:  d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SEQ_RST;
        else        q <= d;
    end

    assign req_ready = (q.state == ST_IDLE);
    assign cs_n      = (q.state != ST_BEAT);
    assign oe_n      = !((q.state == ST_BEAT) && !q.write);
    assign we_n      = !((q.state == ST_BEAT) &&  q.write);
    assign addr_out  = q.addr;
    assign done      = (q.state == ST_GAP);
    assign err       = (q.state == ST_FAULT);

    // Refused write: error next cycle, bus untouched (R9).
    assert_refuse_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && cfg_wprot) |=> (err && we_n && cs_n));

    // Completion is a single cycle, followed by readiness (R10).
    assert_done_then_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready && cs_n));

    // Normal mode: a beat cannot end before the counter expires (R8).
    assert_normal_full_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !q.ext && !cnt_zero) |=> (!cs_n && $stable(addr_out)));

    // Strobe kind does not change while the chip-select stays low (R11).
    assert_strobe_steady_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n) |=> (cs_n || ($stable(we_n) && $stable(oe_n))));

    // Extended reload never exceeds the clamped maximum (R5).
    assert_ext_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state == ST_BEAT) && q.ext) |-> (q.reload <= CNT_W'(EXT_MAX_LEN - 1)));

endmodule

// File: tb/smc_wait_seq_bench.sv
`timescale 1ns/1ps
module smc_wait_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_len = '0;
    logic [15:0] req_addr = '0;
    logic        req_ready;
    logic [4:0]  cfg_rd_wait = '0;
    logic [4:0]  cfg_wr_wait = '0;
    logic        cfg_ext_en = 1'b0;
    logic [9:0]  cfg_ext_wait = '0;
    logic        cfg_wprot = 1'b0;
    logic        ack_in = 1'b0;
    logic        cs_n, oe_n, we_n, done, err;
    logic [15:0] addr_out;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    string cur_tag = "R1";

    always #2.5 clk = ~clk;

    smc_wait_seq u_smc_wait_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_len(req_len), .req_addr(req_addr), .req_ready(req_ready),
        .cfg_rd_wait(cfg_rd_wait), .cfg_wr_wait(cfg_wr_wait),
        .cfg_ext_en(cfg_ext_en), .cfg_ext_wait(cfg_ext_wait),
        .cfg_wprot(cfg_wprot), .ack_in(ack_in), .cs_n(cs_n), .oe_n(oe_n),
        .we_n(we_n), .addr_out(addr_out), .done(done), .err(err)
    );

    // ---------------- behavioural reference model ----------------
    // phase: 0 idle, 1 beat, 2 gap, 3 fault
    int m_ph = 0, m_rem = 0, m_len = 0, m_beats = 0, m_addr = 0;
    bit m_wr = 0, m_ext = 0;
    bit a1 = 0, a2 = 0, a3 = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_rem = 0; m_len = 0; m_beats = 0; m_addr = 0;
            m_wr = 0; m_ext = 0; a1 = 0; a2 = 0; a3 = 0;
        end else begin
            bit pulse;
            pulse = a2 && !a3;
            case (m_ph)
                0: if (req_valid) begin
                    m_addr = int'(req_addr);
                    if (req_write && cfg_wprot) m_ph = 3;
                    else begin
                        int e;
                        m_ph = 1; m_wr = req_write; m_ext = cfg_ext_en;
                        m_beats = int'(req_len);
                        e = (int'(cfg_ext_wait) > 1022) ? 1022 : int'(cfg_ext_wait);
                        if (cfg_ext_en) m_len = (e + 1) * 16;
                        else m_len = (req_write ? int'(cfg_wr_wait) : int'(cfg_rd_wait)) + 1;
                        m_rem = m_len;
                    end
                end
                1: begin
                    if (m_rem == 1 || (m_ext && pulse)) begin
                        if (m_beats == 0) m_ph = 2;
                        else begin
                            m_beats--; m_addr = (m_addr + 1) % 65536; m_rem = m_len;
                        end
                    end else m_rem--;
                end
                default: m_ph = 0;
            endcase
            a3 = a2; a2 = a1; a1 = ack_in;
        end
    end

    // Cycle-by-cycle comparison, sampled away from the active edge.
    always @(negedge clk) begin
        bit e_cs, e_oe, e_we, e_rdy, e_dn, e_er;
        cycles++;
        e_cs  = (m_ph != 1);
        e_oe  = !(m_ph == 1 && !m_wr);
        e_we  = !(m_ph == 1 && m_wr);
        e_rdy = (m_ph == 0);
        e_dn  = (m_ph == 2);
        e_er  = (m_ph == 3);
        checks++;
        if (cs_n !== e_cs || oe_n !== e_oe || we_n !== e_we || req_ready !== e_rdy ||
            done !== e_dn || err !== e_er || int'(addr_out) != m_addr) begin
            errors++;
            $display("FAIL %s model compare @%0d: act cs%b oe%b we%b rdy%b dn%b er%b a%h exp cs%b oe%b we%b rdy%b dn%b er%b a%h",
                     cur_tag, cycles, cs_n, oe_n, we_n, req_ready, done, err, addr_out,
                     e_cs, e_oe, e_we, e_rdy, e_dn, e_er, m_addr[15:0]);
        end
    end

    // Watchdog
    always @(negedge clk) begin
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: act %0d cycles exp completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: act %0d exp %0d", tag, what, act, exp);
        end
    endtask

    task automatic drive_req(bit w, int len, int a);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = w; req_len = 2'(len); req_addr = 16'(a);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Issues one access and counts the cycles with chip-select low.
    task automatic run_access(bit w, int len, int a, int exp_low, string tag);
        int low = 0;
        cur_tag = tag;
        drive_req(w, len, a);
        while (!done) begin
            if (!cs_n) low++;
            @(negedge clk);
        end
        check(low == exp_low, tag, "strobe cycles", low, exp_low);
        check(cs_n && oe_n && we_n && !req_ready, "R10", "done cycle idle bus", req_ready, 0);
        @(negedge clk);
        check(req_ready && !done, "R10", "ready after done", req_ready, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(cs_n && oe_n && we_n && req_ready && !done && !err && addr_out == 0,
              "R1", "reset outputs", {cs_n, oe_n, we_n, req_ready}, 4'b1111);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n && req_ready && !done && !err, "R1", "after reset", req_ready, 1);

        // R2 normal reads
        cfg_rd_wait = 5'd3; cfg_wr_wait = 5'd9;
        run_access(1'b0, 0, 'h0010, 4, "R2");
        cfg_rd_wait = 5'd31;
        run_access(1'b0, 0, 'h0020, 32, "R2");

        // R11 burst with address stepping across a carry
        cfg_rd_wait = 5'd0;
        run_access(1'b0, 3, 'h0FFE, 4, "R11");
        check(addr_out == 16'h1001, "R11", "last beat address", addr_out, 'h1001);

        // R3 normal write
        cfg_wr_wait = 5'd5; cfg_rd_wait = 5'd1;
        run_access(1'b1, 1, 'h0100, 12, "R3");

        // R4 extended timing for both directions
        cfg_ext_en = 1'b1; cfg_ext_wait = 10'd2;
        run_access(1'b0, 0, 'h0200, 48, "R4");
        cfg_ext_wait = 10'd0; cfg_wr_wait = 5'd3;
        run_access(1'b1, 0, 'h0210, 16, "R4");

        // R5 top code clamps
        cfg_ext_wait = 10'd1023;
        run_access(1'b0, 0, 'h0300, 16368, "R5");

        // R6: first beat full, three early ends by separate edges
        cfg_ext_wait = 10'd3;
        fork
            run_access(1'b0, 3, 'h0400, 89, "R6");
            begin
                @(negedge clk); @(negedge clk);   // accept edge, then first beat cycle
                repeat (70) @(negedge clk);
                for (int i = 0; i < 3; i++) begin
                    ack_in = 1'b1; repeat (4) @(negedge clk);
                    ack_in = 1'b0; repeat (4) @(negedge clk);
                end
            end
        join

        // R7: a held level ends only one beat
        cfg_ext_wait = 10'd1;
        fork
            run_access(1'b0, 2, 'h0500, 72, "R7");
            begin
                @(negedge clk); @(negedge clk);
                repeat (5) @(negedge clk);
                ack_in = 1'b1;
            end
        join
        ack_in = 1'b0;
        repeat (4) @(negedge clk);

        // R8: acknowledge ignored in normal mode
        cfg_ext_en = 1'b0; cfg_rd_wait = 5'd6;
        fork
            run_access(1'b0, 1, 'h0600, 14, "R8");
            begin
                for (int i = 0; i < 6; i++) begin
                    @(negedge clk); ack_in = ~ack_in;
                end
                ack_in = 1'b0;
            end
        join
        repeat (4) @(negedge clk);

        // R9: protected write refused, protected read and open write proceed
        cfg_wprot = 1'b1; cur_tag = "R9";
        drive_req(1'b1, 0, 'h0700);
        check(err && cs_n && we_n && oe_n, "R9", "refused write error", err, 1);
        @(negedge clk);
        check(!err && req_ready && cs_n, "R9", "error single cycle", err, 0);
        cfg_rd_wait = 5'd2;
        run_access(1'b0, 0, 'h0710, 3, "R9");
        cfg_wprot = 1'b0; cfg_wr_wait = 5'd4;
        run_access(1'b1, 0, 'h0720, 5, "R9");

        // R12: configuration changed mid-access has no effect
        cfg_rd_wait = 5'd10;
        fork
            run_access(1'b0, 0, 'h0800, 11, "R12");
            begin
                @(negedge clk); @(negedge clk); @(negedge clk);
                cfg_rd_wait = 5'd0; cfg_ext_en = 1'b1; cfg_ext_wait = 10'd0;
                for (int i = 0; i < 6; i++) begin
                    @(negedge clk); ack_in = ~ack_in;
                end
                ack_in = 1'b0;
            end
        join
        cfg_ext_en = 1'b0;

        // R10: back-to-back requests leave exactly two high cycles
        cfg_rd_wait = 5'd1; cur_tag = "R10";
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_len = 2'd0; req_addr = 16'h0900;
        begin
            int gap = 0;
            @(negedge clk);
            while (!done) @(negedge clk);
            while (cs_n) begin gap++; @(negedge clk); end
            check(gap == 2, "R10", "high cycles between accesses", gap, 2);
        end
        req_valid = 1'b0;
        repeat (6) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule